// File: doc/BRIEF.md
# CAN Transmit Buffer Status Controller

This block holds the status of three CAN transmit message buffers. Each buffer has an empty flag. The CPU loads a message into an empty buffer, then writes 1 to that flag to clear it. A cleared flag schedules the buffer for the transmit engine. The flag returns to empty in two cases: the engine reports that the message was sent, or the engine reports that a pending abort request for the buffer has completed. Each buffer also has an abort request bit, set by the CPU, and an abort acknowledge bit, set by the block. These two bits are cross-coupled with the empty flag.

A masked transmit interrupt request is raised while any buffer is empty and its enable bit is set. The enable register is forced to zero while initialization mode is active. Listen mode stops the CPU from scheduling any buffer. A small gate answers CPU requests for access to a buffer's contents: access is refused while the buffer is scheduled.

The CPU port has separate write and read addresses. Writes take effect at the next clock edge. Reads are combinational.

Top module: `can_txbuf_status`

## Requirements
- R1: After reset, the register port reads as follows. Address 0 (empty flags, bits 2:0) reads 0x07. Address 1 (interrupt enables, bits 2:0) reads 0x00. Address 2 (abort requests, bits 2:0) reads 0x00. Address 3 (abort acknowledges, bits 2:0) reads 0x00. Bits 7:3 of every address read 0. `irq_o` and `sched_o` are 0.
- R2: A write of 1 to bit n at address 0 clears empty flag n, and `sched_o[n]` then reads 1. Writing 0 to a flag bit has no effect.
- R3: A `sent_ok_i[n]` pulse while buffer n is scheduled sets empty flag n at the next edge.
- R4: A write of 1 to bit n at address 2 sets abort request n, but only while buffer n is scheduled. The write is ignored on an empty buffer. An `abort_done_i[n]` pulse with the request pending sets empty flag n and abort acknowledge n. An `abort_done_i[n]` pulse with no request pending is ignored.
- R5: When the CPU clears empty flag n, abort acknowledge n is cleared in the same edge.
- R6: Whenever empty flag n becomes set, abort request n is cleared. An abort request is never pending on an empty buffer.
- R7: While `listen_i` is 1, writes that would clear empty flags are ignored, so no buffer becomes scheduled.
- R8: `acc_ok_o` is 1 only when `acc_req_i` is 1 and the buffer selected by `acc_sel_i` (0 to 2) is empty.
- R9: `irq_o` is 1 exactly when some buffer n has both its empty flag and enable bit n set.
- R10: While `init_i` is 1, the enable register reads 0 and ignores writes. It stays 0 after `init_i` falls.
- R11: If a set event and a CPU clear hit the same empty flag in one cycle, the flag ends up set.
- R12: If `sent_ok_i[n]` and `abort_done_i[n]` arrive in the same cycle while an abort is pending, the flag is set and abort acknowledge n stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Initialization mode active |
| listen_i | input | 1 | Listen mode active |
| wr_en_i | input | 1 | CPU write strobe |
| wr_addr_i | input | 2 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| rd_addr_i | input | 2 | CPU read address |
| rd_data_o | output | 8 | CPU read data |
| sent_ok_i | input | 3 | Per-buffer transmission success event |
| abort_done_i | input | 3 | Per-buffer abort completion event |
| sched_o | output | 3 | Per-buffer scheduled for transmission |
| abrq_o | output | 3 | Per-buffer abort request to the engine |
| acc_req_i | input | 1 | CPU request to access buffer contents |
| acc_sel_i | input | 2 | Buffer selected for access |
| acc_ok_o | output | 1 | Access granted |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
The assertions check, on every cycle, the invariants that follow from the coupling of the status bits:
- a set event always leaves the flag set with its abort request gone;
- a falling flag carries no acknowledge;
- no request is pending on an empty buffer;
- listen mode never lets a flag fall;
- initialization mode empties the enable register;
- a grant never coincides with a scheduled buffer.

Only the bench's scenarios show the rest: the exact register values after each write or event sequence, the refusal of abort requests and of abort completions that have no request, the resolution of same-cycle collisions, and the interrupt level after enables and flags change.

// File: rtl/can_txbuf_pkg.sv
package can_txbuf_pkg;
  localparam int unsigned NBUF = 3;
  localparam int unsigned DW   = 8;
  localparam int unsigned AW   = 2;

  typedef enum logic [AW-1:0] {
    ADR_EMPTY = 2'd0,
    ADR_IE    = 2'd1,
    ADR_ABRQ  = 2'd2,
    ADR_ABAK  = 2'd3
  } reg_adr_e;
endpackage

// File: rtl/txb_flag_slice.sv
module txb_flag_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic listen_i,
  input  logic clr_i,
  input  logic abrq_wr_i,
  input  logic sent_ok_i,
  input  logic abort_done_i,
  output logic empty_o,
  output logic abrq_o,
  output logic abak_o
);
  logic empty_q, abrq_q, abak_q;
  logic abort_ok, hw_set, cpu_clr;

  assign abort_ok = !empty_q && abrq_q && abort_done_i;
  assign hw_set   = !empty_q && (sent_ok_i || abort_ok);
  // hardware set beats CPU clear; listen mode blocks scheduling
  assign cpu_clr  = empty_q && clr_i && !listen_i && !hw_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      abrq_q  <= 1'b0;
      abak_q  <= 1'b0;
    end else begin
      if (hw_set)       empty_q <= 1'b1;
      else if (cpu_clr) empty_q <= 1'b0;

      if (hw_set || empty_q)  abrq_q <= 1'b0;
      else if (abrq_wr_i)     abrq_q <= 1'b1;

      if (cpu_clr)                      abak_q <= 1'b0;
      else if (abort_ok && !sent_ok_i)  abak_q <= 1'b1;
    end
  end

  assign empty_o = empty_q;
  assign abrq_o  = abrq_q;
  assign abak_o  = abak_q;

  AST_SET_DROPS_ABRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set |=> (empty_q && !abrq_q)) else $error("set event left flag/abrq wrong"); // R6
  AST_FALL_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty_q) |-> !abak_q) else $error("ack survived flag clear"); // R5
  AST_ABRQ_ON_SCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abrq_q |-> !empty_q) else $error("abort request on empty buffer"); // R4
  AST_LISTEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (listen_i && empty_q) |=> empty_q) else $error("flag cleared in listen mode"); // R7
endmodule

// File: rtl/txb_ie_reg.sv
module txb_ie_reg #(
  parameter int unsigned NBUF = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  input  logic            wr_i,
  input  logic [NBUF-1:0] wdata_i,
  output logic [NBUF-1:0] ie_o
);
  logic [NBUF-1:0] ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ie_q <= '0;
    else if (init_i) ie_q <= '0;
    else if (wr_i)   ie_q <= wdata_i;
  end

  assign ie_o = ie_q;

  AST_INIT_IE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (ie_q == '0)) else $error("enable not held in init"); // R10
endmodule

// File: rtl/txb_acc_gate.sv
module txb_acc_gate #(
  parameter int unsigned NBUF = 3,
  localparam int unsigned SW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            req_i,
  input  logic [SW-1:0]   sel_i,
  input  logic [NBUF-1:0] empty_i,
  output logic            ok_o
);
  logic sel_empty;

  always_comb begin
    sel_empty = 1'b0;
    for (int unsigned i = 0; i < NBUF; i++)
      if (sel_i == SW'(i)) sel_empty = empty_i[i];
  end

  assign ok_o = req_i && sel_empty;
endmodule

// File: rtl/can_txbuf_status.sv
module can_txbuf_status
  import can_txbuf_pkg::*;
#(
  parameter int unsigned N   = NBUF,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          listen_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [N-1:0]  sent_ok_i,
  input  logic [N-1:0]  abort_done_i,
  output logic [N-1:0]  sched_o,
  output logic [N-1:0]  abrq_o,
  input  logic          acc_req_i,
  input  logic [SW-1:0] acc_sel_i,
  output logic          acc_ok_o,
  output logic          irq_o
);
  logic [N-1:0] empty, abrq, abak, ie;
  logic [N-1:0] clr_vec, abrq_wr_vec;
  logic         wr_ie;
  logic         unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[DW-1:N];

  assign clr_vec     = (wr_en_i && wr_addr_i == ADR_EMPTY) ? wr_data_i[N-1:0] : '0;
  assign abrq_wr_vec = (wr_en_i && wr_addr_i == ADR_ABRQ)  ? wr_data_i[N-1:0] : '0;
  assign wr_ie       = wr_en_i && (wr_addr_i == ADR_IE);

  for (genvar g = 0; g < N; g++) begin : g_buf
    txb_flag_slice u_slice (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .listen_i     (listen_i),
      .clr_i        (clr_vec[g]),
      .abrq_wr_i    (abrq_wr_vec[g]),
      .sent_ok_i    (sent_ok_i[g]),
      .abort_done_i (abort_done_i[g]),
      .empty_o      (empty[g]),
      .abrq_o       (abrq[g]),
      .abak_o       (abak[g])
    );
  end

  txb_ie_reg #(.NBUF(N)) u_ie (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init_i),
    .wr_i    (wr_ie),
    .wdata_i (wr_data_i[N-1:0]),
    .ie_o    (ie)
  );

  txb_acc_gate #(.NBUF(N)) u_gate (
    .req_i   (acc_req_i),
    .sel_i   (acc_sel_i),
    .empty_i (empty),
    .ok_o    (acc_ok_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADR_EMPTY: rd_data_o[N-1:0] = empty;
      ADR_IE:    rd_data_o[N-1:0] = ie;
      ADR_ABRQ:  rd_data_o[N-1:0] = abrq;
      ADR_ABAK:  rd_data_o[N-1:0] = abak;
      default:   rd_data_o = '0;
    endcase
  end

  assign sched_o = ~empty;
  assign abrq_o  = abrq;
  assign irq_o   = |(empty & ie);

  AST_NO_GRANT_SCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok_o |-> !sched_o[acc_sel_i]) else $error("access granted to scheduled buffer"); // R8
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !irq_o) else $error("irq while enables held in init"); // R9
endmodule

// File: tb/tb_can_txbuf_status.sv
module tb_can_txbuf_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init = 1'b0, listen = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [2:0] sent_ok = '0, abort_done = '0, sched, abrq;
  logic       acc_req = 1'b0, acc_ok, irq;
  logic [1:0] acc_sel = '0;

  always #10 clk = ~clk;

  can_txbuf_status dut (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .listen_i(listen),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sent_ok_i(sent_ok), .abort_done_i(abort_done),
    .sched_o(sched), .abrq_o(abrq),
    .acc_req_i(acc_req), .acc_sel_i(acc_sel), .acc_ok_o(acc_ok), .irq_o(irq)
  );

  // kind 0..3 register read, 4 irq, 5 sched, 6 acc_ok
  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic flush();
    wait (q.size() == 0);
    #2;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0; wr_data = '0;
  endtask

  // monitor: pops expected items and compares outputs (called away from edges)
  initial begin
    forever begin
      item_t it;
      logic [7:0] act;
      wait (q.size() > 0);
      it = q.pop_front();
      if (it.kind < 4) rd_addr = it.kind[1:0];
      #1;
      case (it.kind)
        4:       act = {7'd0, irq};
        5:       act = {5'd0, sched};
        6:       act = {7'd0, acc_ok};
        default: act = rd_data;
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(0, 8'h07, "R1 flags"); chk(1, 8'h00, "R1 ie"); chk(2, 8'h00, "R1 abrq");
    chk(3, 8'h00, "R1 abak"); chk(4, 8'h00, "R1 irq"); chk(5, 8'h00, "R1 sched");
    flush();

    wr(0, 8'hFA);  // clears buf1 only; upper bits do not matter
    chk(0, 8'h05, "R2 clear buf1"); chk(5, 8'h02, "R2 sched");
    flush();
    wr(0, 8'h00);
    chk(0, 8'h05, "R2 write zero"); flush();

    wr(1, 8'h07);
    chk(4, 8'h01, "R9 irq on"); chk(1, 8'h07, "R9 ie read"); flush();
    wr(1, 8'h02);
    chk(4, 8'h00, "R9 irq off masked"); flush();

    sent_ok = 3'b010; cyc(); sent_ok = '0;
    chk(0, 8'h07, "R3 sent sets flag"); chk(4, 8'h01, "R9 irq after set");
    chk(5, 8'h00, "R3 unsched"); flush();

    wr(0, 8'h01);
    acc_req = 1'b1; acc_sel = 2'd0;
    chk(0, 8'h06, "R2 clear buf0"); chk(6, 8'h00, "R8 blocked"); flush();
    acc_sel = 2'd2;
    chk(6, 8'h01, "R8 granted"); flush();
    acc_req = 1'b0;
    chk(6, 8'h00, "R8 no req"); flush();

    wr(2, 8'h05);
    chk(2, 8'h01, "R4 abrq only on sched"); flush();
    abort_done = 3'b001; cyc(); abort_done = '0;
    chk(0, 8'h07, "R4 abort sets flag"); chk(3, 8'h01, "R4 ack set");
    chk(2, 8'h00, "R6 abrq dropped"); flush();

    wr(0, 8'h01);
    chk(0, 8'h06, "R5 flag cleared"); chk(3, 8'h00, "R5 ack cleared"); flush();

    abort_done = 3'b001; cyc(); abort_done = '0;
    chk(0, 8'h06, "R4 stray abort ignored"); chk(3, 8'h00, "R4 no ack"); flush();

    sent_ok = 3'b001; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h01;
    cyc();
    sent_ok = '0; wr_en = 1'b0; wr_data = '0;
    chk(0, 8'h07, "R11 set wins"); flush();

    wr(0, 8'h01); wr(2, 8'h01);
    chk(2, 8'h01, "R12 abrq pending"); flush();
    sent_ok = 3'b001; abort_done = 3'b001; cyc(); sent_ok = '0; abort_done = '0;
    chk(0, 8'h07, "R12 flag set"); chk(3, 8'h00, "R12 no ack");
    chk(2, 8'h00, "R6 abrq cleared"); flush();

    listen = 1'b1;
    wr(0, 8'h07);
    chk(0, 8'h07, "R7 listen blocks clear"); chk(5, 8'h00, "R7 no sched"); flush();
    listen = 1'b0;

    wr(1, 8'h07);
    init = 1'b1; cyc();
    chk(1, 8'h00, "R10 init forces zero"); chk(4, 8'h00, "R10 irq off"); flush();
    wr(1, 8'h07);
    chk(1, 8'h00, "R10 write ignored in init"); flush();
    init = 1'b0; cyc();
    chk(1, 8'h00, "R10 stays zero"); flush();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule